// File: doc/BRIEF.md
# Byte-Accessed Sample FIFO with Level Thresholds

This block buffers 16-bit conversion results between an acquisition front end and a host that sees only an 8-bit register port. The front end pushes one sample per cycle of `smp_valid`. The host drains each sample with two reads of the data address. Writes to that same address program two fill thresholds. A status byte combines live fill levels with sticky event flags that clear when the host reads them.

An interrupt output is raised when the fill level enters the near-full region and the interrupt is enabled. A self-clearing command bit flushes the buffer. It also rewinds both the read byte phase and the threshold write sequence, so the host can reprogram the thresholds right after a flush.

Top module: `acq_byte_fifo`

## Requirements
- R1: The buffer holds `SAMPLES` samples (2*`SAMPLES` bytes). Status bit0 is 1 while it is empty and status bit2 is 1 while it holds `SAMPLES` samples.
- R2: Reading address 0 returns the low byte of the oldest sample, then its high byte. The sample leaves the buffer on the high-byte read. A read of address 0 while the buffer is empty returns 0x00 and does not change the byte phase.
- R3: Samples come out in the order they were pushed.
- R4: A push while the buffer is full is discarded (even if a read pops in the same cycle) and sets the data-lost event, status bit5.
- R5: After reset or a flush, the first four writes to address 0 are, in order: near-empty threshold low byte, its high byte, near-full threshold low byte, its high byte. Further writes to address 0 are ignored until the next flush. Both thresholds reset to 0.
- R6: Status bit1 (near full) is 1 while the free bytes, 2*(`SAMPLES` - stored), are at or below the near-full threshold. Output `near_empty` is 1 while the stored bytes, 2*stored, are at or below the near-empty threshold.
- R7: When near full goes from 0 to 1, the threshold event (status bit3) is set one cycle later and stays set until it is cleared.
- R8: A cycle with `scan_done` high sets the end-of-scan event, status bit4.
- R9: Reading the status byte (address 1) returns the pre-edge value and clears bits 5, 4 and 3 at that edge. An event arriving in the same cycle as the read survives the read. Bits 7 and 6 mirror `conv_idle` and `conv_running`.
- R10: Writing address 3 with bit0 = 1 flushes the buffer on the next edge. Address 3 reads back bit0 = 1 for that single cycle and 0 afterwards. The flush returns the byte phase to low and the threshold write sequence to its first byte. It keeps the threshold values and the sticky events.
- R11: `irq` equals control bit0 AND the threshold event. It falls after the status read that clears the event. Address 2 reads back the control byte with bit0 in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Push strobe from the conversion side |
| smp_data | input | 16 | Sample to push |
| scan_done | input | 1 | End-of-scan event pulse |
| conv_idle | input | 1 | Converter idle level, shown in status bit7 |
| conv_running | input | 1 | Converter running level, shown in status bit6 |
| host_addr | input | 2 | 0 data, 1 status, 2 control, 3 command |
| host_rd | input | 1 | Read strobe; side effects occur at the clock edge |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte for the current address |
| near_empty | output | 1 | Stored bytes at or below the near-empty threshold |
| irq | output | 1 | Enabled threshold event |

## Verification
The main pattern fills a small buffer one sample at a time through every level from empty to full. At each level the status byte, `near_empty` and `irq` are compared with an arithmetic model, which shows that the thresholds are measured in bytes and that the near-full threshold counts free space rather than stored data. An overfull push followed by a complete drain shows that a discarded sample leaves no trace and that FIFO order and byte order hold. A flush done mid-sample, followed by a second threshold sequence, separates a correct rewind of both byte pointers from one that only empties the storage. Status reads taken while an event is being raised show that a new event outlives the read that clears the old ones.

// File: rtl/asf_pkg.sv
package asf_pkg;
  // status byte bit positions
  localparam int ST_EMPTY = 0;
  localparam int ST_NFULL = 1;
  localparam int ST_FULL  = 2;
  localparam int ST_THR   = 3;
  localparam int ST_EOS   = 4;
  localparam int ST_LOST  = 5;
  localparam int ST_RUN   = 6;
  localparam int ST_IDLE  = 7;

  typedef enum logic [1:0] {
    A_DATA = 2'd0,
    A_STAT = 2'd1,
    A_CTRL = 2'd2,
    A_CMD  = 2'd3
  } addr_e;

  // free space in bytes at or below the programmed free-byte threshold
  function automatic logic near_full_lvl(input int unsigned cap_bytes,
                                         input int unsigned n_samp,
                                         input int unsigned free_thr);
    return (cap_bytes - 2 * n_samp) <= free_thr;
  endfunction

  // stored bytes at or below the programmed threshold
  function automatic logic near_empty_lvl(input int unsigned n_samp,
                                          input int unsigned thr);
    return (2 * n_samp) <= thr;
  endfunction
endpackage

// File: rtl/asf_store.sv
module asf_store #(
  parameter int SAMPLES = 2048,
  parameter int AW = $clog2(SAMPLES),
  parameter int CW = $clog2(SAMPLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [15:0]   push_data,
  input  logic          pop,
  output logic [15:0]   head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          lost
);
  logic [15:0]   mem [SAMPLES];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic          do_wr;
  logic          do_rd;

  assign full  = (count == CW'(SAMPLES));
  assign empty = (count == '0);
  assign do_wr = push && !full && !flush;
  assign do_rd = pop && !empty && !flush;
  assign lost  = push && full && !flush;
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= rd_ptr + 1'b1;
      count <= count + CW'(do_wr) - CW'(do_rd);
    end
  end

  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(SAMPLES));

  a_r4_lost_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
    (lost && !pop) |=> (count == $past(count)));

  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/asf_port.sv
module asf_port (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        rd_data,
  input  logic        wr_data,
  input  logic [7:0]  wdata,
  input  logic        empty,
  output logic        pop,
  output logic        hi_phase,
  output logic [15:0] ne_thr,
  output logic [15:0] nf_thr
);
  localparam logic [2:0] SEQ_DONE = 3'd4;

  logic [2:0] widx;

  assign pop = rd_data && !empty && hi_phase && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_phase <= 1'b0;
      widx     <= '0;
      ne_thr   <= '0;
      nf_thr   <= '0;
    end else if (flush) begin
      hi_phase <= 1'b0;
      widx     <= '0;
    end else begin
      if (rd_data && !empty) hi_phase <= !hi_phase;
      if (wr_data && widx != SEQ_DONE) begin
        case (widx[1:0])
          2'd0:    ne_thr[7:0]  <= wdata;
          2'd1:    ne_thr[15:8] <= wdata;
          2'd2:    nf_thr[7:0]  <= wdata;
          default: nf_thr[15:8] <= wdata;
        endcase
        widx <= widx + 3'd1;
      end
    end
  end

  a_r2_phase_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    hi_phase |-> !empty);

  a_r5_sequence_capped: assert property (@(posedge clk) disable iff (!rst_n)
    widx <= SEQ_DONE);
endmodule

// File: rtl/asf_flags.sv
module asf_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic stat_rd,
  input  logic nf_lvl,
  input  logic lost,
  input  logic eos,
  output logic thr_evt,
  output logic eos_evt,
  output logic lost_evt
);
  logic nf_prev;
  logic thr_set;

  assign thr_set = nf_lvl && !nf_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nf_prev  <= 1'b0;
      thr_evt  <= 1'b0;
      eos_evt  <= 1'b0;
      lost_evt <= 1'b0;
    end else begin
      nf_prev  <= nf_lvl;
      thr_evt  <= (thr_evt && !stat_rd) || thr_set;
      eos_evt  <= (eos_evt && !stat_rd) || eos;
      lost_evt <= (lost_evt && !stat_rd) || lost;
    end
  end

  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !thr_set && !eos && !lost) |=> (!thr_evt && !eos_evt && !lost_evt));

  a_r7_crossing_sets: assert property (@(posedge clk) disable iff (!rst_n)
    thr_set |=> thr_evt);

  a_r8_scan_sets: assert property (@(posedge clk) disable iff (!rst_n)
    eos |=> eos_evt);
endmodule

// File: rtl/acq_byte_fifo.sv
module acq_byte_fifo #(
  parameter int SAMPLES = 2048
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        smp_valid,
  input  logic [15:0] smp_data,
  input  logic        scan_done,
  input  logic        conv_idle,
  input  logic        conv_running,
  input  logic [1:0]  host_addr,
  input  logic        host_rd,
  input  logic        host_wr,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  output logic        near_empty,
  output logic        irq
);
  localparam int CW = $clog2(SAMPLES + 1);
  localparam int CAP_BYTES = 2 * SAMPLES;

  logic          rd_dat, wr_dat, rd_st, wr_ctl, wr_cmd;
  logic          cmd_busy, irq_en;
  logic          pop, hi_phase, full, empty, lost, nf_lvl;
  logic          thr_evt, eos_evt, lost_evt;
  logic [15:0]   head, ne_thr, nf_thr;
  logic [CW-1:0] count;
  logic [7:0]    stat;

  assign rd_dat = host_rd && (host_addr == asf_pkg::A_DATA);
  assign wr_dat = host_wr && (host_addr == asf_pkg::A_DATA);
  assign rd_st  = host_rd && (host_addr == asf_pkg::A_STAT);
  assign wr_ctl = host_wr && (host_addr == asf_pkg::A_CTRL);
  assign wr_cmd = host_wr && (host_addr == asf_pkg::A_CMD);

  asf_store #(.SAMPLES(SAMPLES)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(cmd_busy), .push(smp_valid),
    .push_data(smp_data), .pop(pop), .head(head), .count(count),
    .full(full), .empty(empty), .lost(lost)
  );

  asf_port u_port (
    .clk(clk), .rst_n(rst_n), .flush(cmd_busy), .rd_data(rd_dat),
    .wr_data(wr_dat), .wdata(host_wdata), .empty(empty), .pop(pop),
    .hi_phase(hi_phase), .ne_thr(ne_thr), .nf_thr(nf_thr)
  );

  assign nf_lvl     = asf_pkg::near_full_lvl(CAP_BYTES, 32'(count), 32'(nf_thr));
  assign near_empty = asf_pkg::near_empty_lvl(32'(count), 32'(ne_thr));

  asf_flags u_flags (
    .clk(clk), .rst_n(rst_n), .stat_rd(rd_st), .nf_lvl(nf_lvl),
    .lost(lost), .eos(scan_done), .thr_evt(thr_evt), .eos_evt(eos_evt),
    .lost_evt(lost_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_busy <= 1'b0;
      irq_en   <= 1'b0;
    end else begin
      cmd_busy <= wr_cmd && host_wdata[0];
      if (wr_ctl) irq_en <= host_wdata[0];
    end
  end

  assign irq = irq_en && thr_evt;

  always_comb begin
    stat = '0;
    stat[asf_pkg::ST_EMPTY] = empty;
    stat[asf_pkg::ST_NFULL] = nf_lvl;
    stat[asf_pkg::ST_FULL]  = full;
    stat[asf_pkg::ST_THR]   = thr_evt;
    stat[asf_pkg::ST_EOS]   = eos_evt;
    stat[asf_pkg::ST_LOST]  = lost_evt;
    stat[asf_pkg::ST_RUN]   = conv_running;
    stat[asf_pkg::ST_IDLE]  = conv_idle;
  end

  always_comb begin
    case (host_addr)
      2'd0:    host_rdata = empty ? 8'h00 : (hi_phase ? head[15:8] : head[7:0]);
      2'd1:    host_rdata = stat;
      2'd2:    host_rdata = {7'b0, irq_en};
      default: host_rdata = {7'b0, cmd_busy};
    endcase
  end

  a_r10_cmd_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_busy && !wr_cmd) |=> !cmd_busy);
endmodule

// File: tb/acq_byte_fifo_bench.sv
module acq_byte_fifo_bench;
  localparam int N = 8;
  localparam int CAP = 2 * N;

  logic        clk = 1'b0;
  logic        rst_n, smp_valid, scan_done, conv_idle, conv_running;
  logic        host_rd, host_wr, near_empty, irq;
  logic [15:0] smp_data;
  logic [1:0]  host_addr;
  logic [7:0]  host_wdata, host_rdata;

  always #10 clk = ~clk;

  acq_byte_fifo #(.SAMPLES(N)) u_acq_byte_fifo (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .scan_done(scan_done), .conv_idle(conv_idle), .conv_running(conv_running),
    .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .near_empty(near_empty), .irq(irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  int cnt = 0;
  int nf_t = 0;
  int ne_t = 0;
  bit nf_old = 0;
  bit e_thr = 0, e_eos = 0, e_lost = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic bit nf_m(input int c);
    return (CAP - 2 * c) <= nf_t;
  endfunction

  function automatic logic [7:0] st_exp();
    return {conv_idle, conv_running, e_lost, e_eos, e_thr,
            1'(cnt == N), nf_m(cnt), 1'(cnt == 0)};
  endfunction

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    host_addr = a;
    host_rd = 1'b1;
    #1 v = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    host_addr = a;
    host_wdata = d;
    host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic push(input logic [15:0] d);
    smp_valid = 1'b1;
    smp_data = d;
    @(negedge clk);
    smp_valid = 1'b0;
    @(negedge clk);
    if (cnt == N) e_lost = 1;
    else begin
      cnt++;
      if (nf_m(cnt) && !nf_old) e_thr = 1;
    end
    nf_old = nf_m(cnt);
  endtask

  task automatic chk_status(input string tag);
    logic [7:0] v;
    logic [7:0] e;
    e = st_exp();
    rd(2'd1, v);
    check(tag, v, e);
    e_thr = 0; e_eos = 0; e_lost = 0;
  endtask

  task automatic rd_byte(input string tag, input logic [7:0] e, input bit pops);
    logic [7:0] v;
    rd(2'd0, v);
    check(tag, v, e);
    if (pops) begin cnt--; nf_old = nf_m(cnt); end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not complete)");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 0; smp_valid = 0; smp_data = '0; scan_done = 0;
    conv_idle = 1; conv_running = 0;
    host_addr = '0; host_rd = 0; host_wr = 0; host_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // reset state
    chk_status("R1 R9 reset status");
    rd(2'd3, v); check("R10 command idle after reset", v, 0);
    rd(2'd2, v); check("R11 control after reset", v, 0);
    check("R11 irq after reset", irq, 0);
    check("R6 near_empty after reset", near_empty, 1);

    // enable interrupt, program thresholds: near-empty 4 bytes, near-full 6 free bytes
    wr(2'd2, 8'h01);
    rd(2'd2, v); check("R11 control readback", v, 1);
    wr(2'd0, 8'h04); wr(2'd0, 8'h00); wr(2'd0, 8'h06); wr(2'd0, 8'h00);
    ne_t = 4; nf_t = 6;
    wr(2'd0, 8'hFF); // fifth write must be ignored (R5)

    // fill sweep across every level
    for (int c = 1; c <= N; c++) begin
      push(16'hA000 + 16'(c) * 16'h0111);
      check($sformatf("R11 irq at level %0d", c), irq, int'(e_thr));
      check($sformatf("R6 near_empty at level %0d", c), near_empty, int'(2 * cnt <= ne_t));
      chk_status($sformatf("R1 R5 R6 R7 status at level %0d", c));
      check($sformatf("R11 irq cleared at level %0d", c), irq, 0);
    end

    // overfull push is dropped
    push(16'hDEAD);
    chk_status("R4 data lost on full push");

    // end of scan, with set during the clearing read
    conv_idle = 0; conv_running = 1;
    scan_done = 1;
    rd(2'd1, v);
    scan_done = 0;
    check("R9 read during event shows old value", v, st_exp());
    e_eos = 1;
    chk_status("R8 R9 event survives same-cycle read");
    chk_status("R9 event cleared by read");

    // drain and check order and byte order
    for (int c = 1; c <= N; c++) begin
      logic [15:0] s;
      s = 16'hA000 + 16'(c) * 16'h0111;
      rd_byte($sformatf("R2 R3 low byte %0d", c), s[7:0], 0);
      rd_byte($sformatf("R2 R3 high byte %0d", c), s[15:8], 1);
    end
    rd_byte("R2 empty read", 8'h00, 0);
    chk_status("R1 status empty after drain");
    push(16'h1234);
    rd_byte("R2 phase unaffected by empty read", 8'h34, 0);
    rd_byte("R2 high byte after empty read", 8'h12, 1);
    chk_status("R7 no event on falling level");

    // flush in mid-sample
    push(16'h5501); push(16'h5502); push(16'h5503);
    rd_byte("R2 low byte before flush", 8'h01, 0);
    wr(2'd3, 8'h01);
    rd(2'd3, v); check("R10 command busy for one cycle", v, 1);
    rd(2'd3, v); check("R10 command self-clears", v, 0);
    cnt = 0; nf_old = nf_m(0);
    chk_status("R10 flush empties");

    // rewritten thresholds: near-full with 14 free bytes, near-empty 0
    wr(2'd0, 8'h00); wr(2'd0, 8'h00); wr(2'd0, 8'h0E); wr(2'd0, 8'h00);
    nf_t = 14; ne_t = 0;
    push(16'h7788);
    check("R10 R11 irq after rewritten threshold", irq, 1);
    check("R6 near_empty with zero threshold", near_empty, 0);
    chk_status("R5 R10 threshold sequence restarted");
    rd_byte("R10 phase restarted low", 8'h88, 0);
    rd_byte("R10 high byte", 8'h77, 1);

    // event without interrupt enable
    wr(2'd2, 8'h00);
    push(16'h99AA);
    check("R11 irq masked", irq, 0);
    chk_status("R7 event set while masked");

    done = 1;
    finish_run();
  end
endmodule